// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's execute stage and, at every event boundary the core signals, chooses between a pending synchronous exception and an external interrupt request. It then performs the entry into the handler. The old status word, program counter and stack register are saved. The status word is raised to privileged, blocked and alternate-bank state. The event code is logged, and the new program counter is formed from the vector base or from the fixed reset address.

The core supplies its current architectural state (PC, status word, vector base, R15), a delay-slot flag and a sleep flag. An interrupt controller outside the block receives the current interrupt mask and answers with a vector and a valid flag. All results are registered and change only in the cycle after an accepted entry. A one-cycle pulse marks each entry. Two further pulses tell the core to drop its delay-slot state and to leave sleep.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception is pending at a boundary (`evt_boundary`=1), it is taken even if an interrupt with a valid vector is requested in the same cycle; `expevt_o` receives the exception code and `intevt_o` is unchanged.
- R2: While the block bit (status bit 28) is 1, a pending exception with any code other than 0x1E0 is taken as code 0x000 with reset-class handling. Code 0x1E0 is taken unchanged and vectors to base+0x100.
- R3: While status bit 28 is 1, an interrupt request causes no entry unless `sleep_i` is 1.
- R4: On every entry, `ssr_o` takes the input status word, `sgr_o` takes `r15_i`, and `sr_o` is the input status word with bits 28, 29 and 30 set, plus any change required by R6.
- R5: If `in_dslot_i` is 1 at entry, `spc_o` is `pc_i`-2 and `dslot_clr_o` pulses for one cycle.
- R6: Codes 0x000, 0x020 and 0x140 are reset-class. They clear status bit 15, set status bits 7:4 to 0xF and set `pc_o` to 0xA0000000.
- R7: Codes 0x040 and 0x060 set `pc_o` to `vbr_i`+0x400. Every other non-reset exception sets `pc_o` to `vbr_i`+0x100. Each exception entry writes its final code to `expevt_o`.
- R8: Code 0x160 adds 2 to the saved PC, applied after any R5 rewind, so with the delay-slot flag set `spc_o` equals `pc_i`.
- R9: `irq_mask_o` always equals status bits 7:4. An accepted interrupt with `irq_vec_valid_i`=1 writes `irq_vec_i` to `intevt_o` and sets `pc_o` to `vbr_i`+0x600. With `irq_vec_valid_i`=0, no entry occurs.
- R10: `wake_o` pulses for one cycle when an entry is accepted while `sleep_i` is 1.
- R11: `taken_o` is 1 in exactly the cycle after an accepted entry. No entry occurs when `evt_boundary` is 0, and all saved and output registers hold their values between entries.
- R12: After reset, every output register and pulse is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_boundary | input | 1 | Core is at an event boundary; decision taken this cycle |
| exc_pending_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | External interrupt request |
| irq_vec_valid_i | input | 1 | Controller has a source above the mask |
| irq_vec_i | input | 12 | Vector code from the controller |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| vbr_i | input | 32 | Vector base |
| r15_i | input | 32 | Current stack register |
| in_dslot_i | input | 1 | Faulting instruction sits in a delay slot |
| sleep_i | input | 1 | Core is asleep |
| irq_mask_o | output | 4 | Current interrupt mask sent to the controller |
| pc_o | output | 32 | New program counter |
| sr_o | output | 32 | New status word |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack register |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt vector |
| taken_o | output | 1 | One-cycle entry pulse |
| dslot_clr_o | output | 1 | One-cycle pulse: clear delay-slot flags |
| wake_o | output | 1 | One-cycle pulse: leave sleep |

## Verification
A wrong arbitration or promotion decision appears in the very next cycle as the wrong code in `expevt_o`, a wrong `pc_o` class, or a `taken_o` pulse that should not be there. A wrong save or rewind shows as an off-by-two `spc_o` in that same cycle. Because the registers hold between entries, a stray update is caught by comparing outputs before and after a boundary that must not be accepted. Table rows cover each vector class, the promotion path, blocked and sleeping interrupts, and the combined trap and delay-slot adjustment.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN_D   = 32;
  localparam int unsigned CODE_W_D = 12;
  localparam int unsigned MASK_W_D = 4;

  localparam int unsigned SR_BLK   = 28;
  localparam int unsigned SR_BANK  = 29;
  localparam int unsigned SR_PRIV  = 30;
  localparam int unsigned SR_FPOFF = 15;
  localparam int unsigned SR_MLSB  = 4;

  localparam logic [CODE_W_D-1:0] C_POWER = 12'h000;
  localparam logic [CODE_W_D-1:0] C_MANUAL = 12'h020;
  localparam logic [CODE_W_D-1:0] C_RDMISS = 12'h040;
  localparam logic [CODE_W_D-1:0] C_WRMISS = 12'h060;
  localparam logic [CODE_W_D-1:0] C_MULTI = 12'h140;
  localparam logic [CODE_W_D-1:0] C_TRAP = 12'h160;
  localparam logic [CODE_W_D-1:0] C_UNBLK = 12'h1E0;

  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_EXC  = 2'd1,
    ENT_IRQ  = 2'd2
  } ent_kind_e;

  typedef enum logic [1:0] {
    VC_RESET = 2'd0,
    VC_MISS  = 2'd1,
    VC_GEN   = 2'd2,
    VC_INT   = 2'd3
  } vec_class_e;

  function automatic vec_class_e classify(ent_kind_e k, logic [CODE_W_D-1:0] c);
    if (k == ENT_IRQ) return VC_INT;
    if (c == C_POWER || c == C_MANUAL || c == C_MULTI) return VC_RESET;
    if (c == C_RDMISS || c == C_WRMISS) return VC_MISS;
    return VC_GEN;
  endfunction
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              exc_pending,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              vec_valid,
  input  logic [CODE_W-1:0] irq_vec,
  input  logic              blocked,
  input  logic              asleep,
  output ent_kind_e         kind,
  output logic [CODE_W-1:0] code_fin,
  output logic [CODE_W-1:0] evt_val
);
  logic irq_ok;

  assign irq_ok = irq_req && vec_valid && (!blocked || asleep);

  always_comb begin
    kind     = ENT_NONE;
    code_fin = exc_code;
    if (boundary) begin
      if (exc_pending) begin
        kind = ENT_EXC;
        if (blocked && exc_code != CODE_W'(C_UNBLK)) code_fin = CODE_W'(C_POWER);
      end else if (irq_ok) begin
        kind = ENT_IRQ;
      end
    end
  end

  assign evt_val = (kind == ENT_IRQ) ? irq_vec : code_fin;

  // R1: an exception at a boundary wins over any interrupt
  p_exc_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && exc_pending) |-> (kind == ENT_EXC));

  // R2: blocked exceptions other than the unblockable one become reset code
  p_promote_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && exc_pending && blocked && exc_code != CODE_W'(C_UNBLK))
      |-> (evt_val == CODE_W'(C_POWER)));

  // R3: a blocked, awake core never accepts an interrupt
  p_blk_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !asleep) |-> (kind != ENT_IRQ));
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int unsigned XLEN   = XLEN_D,
  parameter int unsigned CODE_W = CODE_W_D,
  parameter int unsigned MASK_W = MASK_W_D,
  parameter logic [31:0] RESET_VEC = 32'hA000_0000,
  parameter logic [31:0] OFS_GEN   = 32'h0000_0100,
  parameter logic [31:0] OFS_MISS  = 32'h0000_0400,
  parameter logic [31:0] OFS_INT   = 32'h0000_0600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ent_kind_e         kind,
  input  logic [CODE_W-1:0] code_fin,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   sr,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_dslot,
  output logic [XLEN-1:0]   tgt_pc,
  output logic [XLEN-1:0]   save_pc,
  output logic [XLEN-1:0]   sr_new
);
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  vec_class_e       vcls;
  logic             is_trap;
  logic [XLEN-1:0]  rewound;

  assign vcls    = classify(kind, code_fin);
  assign is_trap = (kind == ENT_EXC) && (code_fin == CODE_W'(C_TRAP));

  always_comb begin
    rewound = in_dslot ? (pc - STEP) : pc;
    save_pc = is_trap ? (rewound + STEP) : rewound;
  end

  always_comb begin
    unique case (vcls)
      VC_RESET: tgt_pc = XLEN'(RESET_VEC);
      VC_MISS:  tgt_pc = vbr + XLEN'(OFS_MISS);
      VC_INT:   tgt_pc = vbr + XLEN'(OFS_INT);
      default:  tgt_pc = vbr + XLEN'(OFS_GEN);
    endcase
  end

  always_comb begin
    sr_new = sr;
    sr_new[SR_BLK]  = 1'b1;
    sr_new[SR_BANK] = 1'b1;
    sr_new[SR_PRIV] = 1'b1;
    if (vcls == VC_RESET) begin
      sr_new[SR_FPOFF] = 1'b0;
      sr_new[SR_MLSB +: MASK_W] = '1;
    end
  end

  // R6: reset-class entries go to the fixed address with mask raised
  p_rst_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ENT_EXC && (code_fin == CODE_W'(C_POWER) || code_fin == CODE_W'(C_MULTI)))
      |-> (tgt_pc == XLEN'(RESET_VEC) && sr_new[SR_MLSB +: MASK_W] == '1));

  // R8: trap with delay slot nets to zero adjustment
  p_trap_ds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_trap && in_dslot) |-> (save_pc == pc));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned XLEN   = XLEN_D,
  parameter int unsigned CODE_W = CODE_W_D,
  parameter int unsigned MASK_W = MASK_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_boundary,
  input  logic              exc_pending_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              irq_vec_valid_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic              in_dslot_i,
  input  logic              sleep_i,
  output logic [MASK_W-1:0] irq_mask_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic              taken_o,
  output logic              dslot_clr_o,
  output logic              wake_o
);
  ent_kind_e         kind;
  logic [CODE_W-1:0] code_fin;
  logic [CODE_W-1:0] evt_val;
  logic [XLEN-1:0]   tgt_pc;
  logic [XLEN-1:0]   save_pc;
  logic [XLEN-1:0]   sr_new;
  logic              ent;
  logic              exc_en;
  logic              irq_en;

  logic [XLEN-1:0]   pc_d, sr_d, ssr_d, spc_d, sgr_d;
  logic [CODE_W-1:0] expevt_d, intevt_d;
  logic              taken_d, dclr_d, wake_d;

  assign irq_mask_o = sr_i[SR_MLSB +: MASK_W];

  exc_select #(.CODE_W(CODE_W)) i_select (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary    (evt_boundary),
    .exc_pending (exc_pending_i),
    .exc_code    (exc_code_i),
    .irq_req     (irq_req_i),
    .vec_valid   (irq_vec_valid_i),
    .irq_vec     (irq_vec_i),
    .blocked     (sr_i[SR_BLK]),
    .asleep      (sleep_i),
    .kind        (kind),
    .code_fin    (code_fin),
    .evt_val     (evt_val)
  );

  exc_target #(.XLEN(XLEN), .CODE_W(CODE_W), .MASK_W(MASK_W)) i_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .code_fin (code_fin),
    .pc       (pc_i),
    .sr       (sr_i),
    .vbr      (vbr_i),
    .in_dslot (in_dslot_i),
    .tgt_pc   (tgt_pc),
    .save_pc  (save_pc),
    .sr_new   (sr_new)
  );

  assign ent    = (kind != ENT_NONE);
  assign exc_en = (kind == ENT_EXC);
  assign irq_en = (kind == ENT_IRQ);

  always_comb begin
    pc_d     = pc_o;
    sr_d     = sr_o;
    ssr_d    = ssr_o;
    spc_d    = spc_o;
    sgr_d    = sgr_o;
    expevt_d = expevt_o;
    intevt_d = intevt_o;
    if (ent) begin
      pc_d  = tgt_pc;
      sr_d  = sr_new;
      ssr_d = sr_i;
      spc_d = save_pc;
      sgr_d = r15_i;
    end
    if (exc_en) expevt_d = evt_val;
    if (irq_en) intevt_d = evt_val;
    taken_d = ent;
    dclr_d  = ent && in_dslot_i;
    wake_d  = ent && sleep_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o        <= '0;
      sr_o        <= '0;
      ssr_o       <= '0;
      spc_o       <= '0;
      sgr_o       <= '0;
      expevt_o    <= '0;
      intevt_o    <= '0;
      taken_o     <= 1'b0;
      dslot_clr_o <= 1'b0;
      wake_o      <= 1'b0;
    end else begin
      pc_o        <= pc_d;
      sr_o        <= sr_d;
      ssr_o       <= ssr_d;
      spc_o       <= spc_d;
      sgr_o       <= sgr_d;
      expevt_o    <= expevt_d;
      intevt_o    <= intevt_d;
      taken_o     <= taken_d;
      dslot_clr_o <= dclr_d;
      wake_o      <= wake_d;
    end
  end

  // R11: no boundary, no pulse in the following cycle
  p_no_bnd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_boundary |=> !taken_o);

  // R11: registers hold when no entry was made
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> ($stable(pc_o) && $stable(spc_o) && $stable(sr_o)));

  // R4: entered status always privileged, blocked, alternate bank
  p_sr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (sr_o[SR_BLK] && sr_o[SR_BANK] && sr_o[SR_PRIV]));

  // R5: delay-slot clear only accompanies an entry
  p_dclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_clr_o |-> taken_o);

  // R10: wake only accompanies an entry
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> taken_o);

  // R9: interrupt log changes only through an accepted interrupt
  p_intevt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en) |=> $stable(intevt_o));
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_boundary, exc_pending_i, irq_req_i, irq_vec_valid_i;
  logic [11:0] exc_code_i, irq_vec_i;
  logic [31:0] pc_i, sr_i, vbr_i, r15_i;
  logic        in_dslot_i, sleep_i;
  logic [3:0]  irq_mask_o;
  logic [31:0] pc_o, sr_o, ssr_o, spc_o, sgr_o;
  logic [11:0] expevt_o, intevt_o;
  logic        taken_o, dslot_clr_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (.*);

  localparam logic [31:0] PC  = 32'h8C00_1000;
  localparam logic [31:0] VBR = 32'h8C00_0000;
  localparam logic [31:0] R15 = 32'h1234_5678;

  typedef struct packed {
    logic        exc;
    logic [11:0] code;
    logic        irq;
    logic        vv;
    logic [11:0] vec;
    logic [31:0] sr;
    logic        ds;
    logic        sl;
    logic        tk;
    logic [31:0] pc;
    logic [31:0] spc;
    logic [31:0] srn;
    logic [11:0] evt;
    logic        isirq;
  } row_t;

  localparam int NROW = 14;
  localparam row_t TBL [NROW] = '{
    // R7 read miss
    '{1'b1, 12'h040, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 1'b0, 1'b0,
      1'b1, 32'h8C00_0400, 32'h8C00_1000, 32'h7000_0030, 12'h040, 1'b0},
    // R5 R7 write miss in delay slot
    '{1'b1, 12'h060, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 1'b1, 1'b0,
      1'b1, 32'h8C00_0400, 32'h8C00_0FFE, 32'h7000_0030, 12'h060, 1'b0},
    // R7 general
    '{1'b1, 12'h0A0, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 1'b0, 1'b0,
      1'b1, 32'h8C00_0100, 32'h8C00_1000, 32'h7000_0030, 12'h0A0, 1'b0},
    // R8 trap
    '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 1'b0, 1'b0,
      1'b1, 32'h8C00_0100, 32'h8C00_1002, 32'h7000_0030, 12'h160, 1'b0},
    // R6 manual reset clears bit 15
    '{1'b1, 12'h020, 1'b0, 1'b0, 12'h000, 32'h0000_8030, 1'b0, 1'b0,
      1'b1, 32'hA000_0000, 32'h8C00_1000, 32'h7000_00F0, 12'h020, 1'b0},
    // R6 multi-hit
    '{1'b1, 12'h140, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 1'b0, 1'b0,
      1'b1, 32'hA000_0000, 32'h8C00_1000, 32'h7000_00F0, 12'h140, 1'b0},
    // R1 exception beats interrupt
    '{1'b1, 12'h0E0, 1'b1, 1'b1, 12'h320, 32'h0000_0030, 1'b0, 1'b0,
      1'b1, 32'h8C00_0100, 32'h8C00_1000, 32'h7000_0030, 12'h0E0, 1'b0},
    // R9 interrupt accepted
    '{1'b0, 12'h000, 1'b1, 1'b1, 12'h320, 32'h0000_0030, 1'b0, 1'b0,
      1'b1, 32'h8C00_0600, 32'h8C00_1000, 32'h7000_0030, 12'h320, 1'b1},
    // R9 nothing above mask
    '{1'b0, 12'h000, 1'b1, 1'b0, 12'h320, 32'h0000_0030, 1'b0, 1'b0,
      1'b0, 32'h0, 32'h0, 32'h0, 12'h0, 1'b0},
    // R2 blocked exception promoted
    '{1'b1, 12'h0A0, 1'b0, 1'b0, 12'h000, 32'h1000_0030, 1'b0, 1'b0,
      1'b1, 32'hA000_0000, 32'h8C00_1000, 32'h7000_00F0, 12'h000, 1'b0},
    // R2 unblockable code kept
    '{1'b1, 12'h1E0, 1'b0, 1'b0, 12'h000, 32'h1000_0030, 1'b0, 1'b0,
      1'b1, 32'h8C00_0100, 32'h8C00_1000, 32'h7000_0030, 12'h1E0, 1'b0},
    // R3 blocked interrupt while awake
    '{1'b0, 12'h000, 1'b1, 1'b1, 12'h5A0, 32'h1000_0030, 1'b0, 1'b0,
      1'b0, 32'h0, 32'h0, 32'h0, 12'h0, 1'b0},
    // R3 R10 blocked interrupt while asleep
    '{1'b0, 12'h000, 1'b1, 1'b1, 12'h5A0, 32'h1000_0030, 1'b0, 1'b1,
      1'b1, 32'h8C00_0600, 32'h8C00_1000, 32'h7000_0030, 12'h5A0, 1'b1},
    // R8 R5 trap in delay slot
    '{1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 32'h0000_0030, 1'b1, 1'b0,
      1'b1, 32'h8C00_0100, 32'h8C00_1000, 32'h7000_0030, 12'h160, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_boundary = 0; exc_pending_i = 0; exc_code_i = 0; irq_req_i = 0;
    irq_vec_valid_i = 0; irq_vec_i = 0; in_dslot_i = 0; sleep_i = 0;
    pc_i = PC; vbr_i = VBR; r15_i = R15; sr_i = 32'h0000_0030;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] prev_pc, prev_spc, prev_exp, prev_int;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pc", pc_o, 0);
    chk("R12 sr", sr_o, 0);
    chk("R12 spc", spc_o, 0);
    chk("R12 expevt", 32'(expevt_o), 0);
    chk("R12 pulses", {29'b0, taken_o, dslot_clr_o, wake_o}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      prev_pc = pc_o; prev_spc = spc_o;
      prev_exp = 32'(expevt_o); prev_int = 32'(intevt_o);
      exc_pending_i = TBL[i].exc; exc_code_i = TBL[i].code;
      irq_req_i = TBL[i].irq; irq_vec_valid_i = TBL[i].vv; irq_vec_i = TBL[i].vec;
      sr_i = TBL[i].sr; in_dslot_i = TBL[i].ds; sleep_i = TBL[i].sl;
      evt_boundary = 1;
      @(negedge clk);
      evt_boundary = 0;
      chk($sformatf("R11 taken row%0d", i), 32'(taken_o), 32'(TBL[i].tk));
      if (TBL[i].tk) begin
        chk($sformatf("R7 pc row%0d", i), pc_o, TBL[i].pc);
        chk($sformatf("R5 spc row%0d", i), spc_o, TBL[i].spc);
        chk($sformatf("R4 sr row%0d", i), sr_o, TBL[i].srn);
        chk($sformatf("R4 ssr row%0d", i), ssr_o, TBL[i].sr);
        chk($sformatf("R4 sgr row%0d", i), sgr_o, R15);
        if (TBL[i].isirq) begin
          chk($sformatf("R9 intevt row%0d", i), 32'(intevt_o), 32'(TBL[i].evt));
          chk($sformatf("R1 expevt kept row%0d", i), 32'(expevt_o), prev_exp);
        end else begin
          chk($sformatf("R7 expevt row%0d", i), 32'(expevt_o), 32'(TBL[i].evt));
          chk($sformatf("R1 intevt kept row%0d", i), 32'(intevt_o), prev_int);
        end
        chk($sformatf("R5 dslot_clr row%0d", i), 32'(dslot_clr_o), 32'(TBL[i].ds));
        chk($sformatf("R10 wake row%0d", i), 32'(wake_o), 32'(TBL[i].sl));
      end else begin
        chk($sformatf("R3 pc held row%0d", i), pc_o, prev_pc);
        chk($sformatf("R3 spc held row%0d", i), spc_o, prev_spc);
      end
      idle_inputs();
      @(negedge clk);
      chk($sformatf("R11 pulse ends row%0d", i), 32'(taken_o), 0);
    end

    // R11: pending exception without boundary is not taken
    prev_pc = pc_o;
    exc_pending_i = 1; exc_code_i = 12'h040; pc_i = 32'h0000_4000;
    @(negedge clk);
    @(negedge clk);
    chk("R11 no boundary taken", 32'(taken_o), 0);
    chk("R11 no boundary pc", pc_o, prev_pc);
    idle_inputs();

    // R9: mask follows status bits 7:4
    sr_i = 32'h0000_00A0;
    #1;
    chk("R9 mask A", 32'(irq_mask_o), 32'hA);
    sr_i = 32'hFFFF_FF5F;
    #1;
    chk("R9 mask 5", 32'(irq_mask_o), 32'h5);
    idle_inputs();

    // R6: power-on code in user state from a different vbr
    vbr_i = 32'h0000_8000; exc_pending_i = 1; exc_code_i = 12'h000;
    sr_i = 32'h0000_8000; evt_boundary = 1;
    @(negedge clk);
    evt_boundary = 0;
    chk("R6 reset pc", pc_o, 32'hA000_0000);
    chk("R6 reset sr", sr_o, 32'h7000_00F0);
    idle_inputs();
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule